// File: doc/BRIEF.md
# Effective Address Translation Selector

This block decides how one 32-bit effective address becomes a 32-bit physical address. A request carries the address, a flag that says whether it is an instruction fetch or a data access, and a translation-enable bit. With translation off, the address passes straight through. With translation on, two lookups run side by side on the same address. One searches a small array of block-translation entries; the instruction array is used for fetches and the data array for data accesses. The other reads one of sixteen segment descriptors, picked by the top four address bits.

A hit in the block array decides the result, and the segment path is discarded. Without a block hit, the selected descriptor either marks the segment as direct-store, which ends the request with a storage fault of the matching kind, or supplies a virtual segment ID. In the second case a 52-bit virtual address goes to an external page-table port, and the physical page number that comes back is joined with the 12-bit page offset.

Segment descriptors and block entries are loaded through simple write strobes. Each request reads them once, when the request is accepted. Results come out through a valid/ready pair and stay stable until they are taken.

Top module: `ea_xlate_select`

## Requirements
- R1: With `reqXlateOn` low, the cycle after acceptance gives `outValid`=1, `outAddr` equal to the request address, `outSrc`=0 (real) and `outFault`=0, with no page-table request raised.
- R2: Without a block hit and for a segment not marked direct-store, `pgReqValid` rises the cycle after acceptance and stays high until `pgRspValid`. `pgReqVaddr` holds {VSID of segment register EA[31:28], EA[27:0]}, 52 bits.
- R3: Without a block hit, a direct-store segment gives no page-table request. The cycle after acceptance it gives `outSrc`=2, `outAddr`=0, and `outFault`=1 (data-storage fault, vector 0x300) for a data access or `outFault`=2 (instruction-storage fault, vector 0x400) for a fetch.
- R4: A page result appears the cycle after `pgRspValid`, with `outAddr`={`pgRspPfn`, EA[11:0]}, `outSrc`=2 and `outFault`=0.
- R5: A valid block entry matches when its tag bits [14:11] equal EA[31:28] and its tag bits [10:0] equal EA[27:17] wherever its mask bit is 0. The result is {base[14:11], (base[10:0] AND NOT mask) OR (EA[27:17] AND mask), EA[16:0]}, with `outSrc`=1 the cycle after acceptance.
- R6: A block hit overrides both the page path and a direct-store segment: no page-table request and no fault.
- R7: Fetches (`reqIsInstr`=1) search only the instruction entries, and data accesses search only the data entries.
- R8: When several entries of the searched array match, the lowest-numbered one supplies the address.
- R9: `reqReady` is high only while idle. A result stays valid and unchanged until `outReady` is high at a clock edge, and `outValid` falls the cycle after that.
- R10: A configuration write made while a request is in flight does not change that request's virtual address or result. It applies to the next request.
- R11: After reset, `reqReady`=1, `outValid`=0 and `pgReqValid`=0. All block entries are invalid and every segment register holds VSID 0 with the direct-store bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqAddr | input | 32 | Effective address |
| reqIsInstr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| reqXlateOn | input | 1 | Translation enabled |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Consumer takes the result |
| outAddr | output | 32 | Physical address (0 on a fault) |
| outSrc | output | 2 | 0 real, 1 block, 2 page |
| outFault | output | 2 | 0 none, 1 data-storage, 2 instruction-storage |
| pgReqValid | output | 1 | Page-table search request |
| pgReqVaddr | output | 52 | Virtual address for the search |
| pgRspValid | input | 1 | Search response present |
| pgRspPfn | input | 20 | Physical page number returned |
| cfgSegWe | input | 1 | Segment register write strobe |
| cfgSegIdx | input | 4 | Segment register index |
| cfgSegVsid | input | 24 | Virtual segment ID to write |
| cfgSegDirect | input | 1 | Direct-store bit to write |
| cfgBatWe | input | 1 | Block entry write strobe |
| cfgBatInstr | input | 1 | 1 selects the instruction array, 0 the data array |
| cfgBatIdx | input | 2 | Entry index |
| cfgBatTag | input | 15 | Effective tag (EA[31:17]) |
| cfgBatMask | input | 11 | Block-length mask over EA[27:17] |
| cfgBatBase | input | 15 | Physical base (PA[31:17]) |
| cfgBatValid | input | 1 | Entry valid bit |

## Verification
Real, block and fault results are due one cycle after the acceptance edge. A page request is due that same cycle, and the page result one cycle after the edge that samples `pgRspValid`. The bench drives every input on the falling edge and checks at the next falling edge, so each comparison lands exactly one register stage after its cause. To show that results are held, the bench keeps `outReady` low for several cycles and checks the outputs again at each falling edge. Configuration writes made during a page walk are checked at the falling edge after the write, before the response arrives.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    SRC_REAL  = 2'd0,
    SRC_BLOCK = 2'd1,
    SRC_PAGE  = 2'd2
  } srcE;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_DATA  = 2'd1,
    FLT_INSTR = 2'd2
  } faultE;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // take request, snapshot descriptor and block lookup
    logic loadPage;  // merge page response into result
  } strobeT;

endpackage

// File: rtl/xlate_bat_array.sv
module xlate_bat_array #(
  parameter int NUM_BAT  = 4,
  parameter int EA_W     = 32,
  parameter int SEG_BITS = 4,
  parameter int BLK_OFF  = 17,
  localparam int TAG_W   = EA_W - BLK_OFF,
  localparam int MASK_W  = EA_W - SEG_BITS - BLK_OFF,
  localparam int BIDX_W  = (NUM_BAT > 1) ? $clog2(NUM_BAT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [BIDX_W-1:0] wrIdx,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [MASK_W-1:0] wrMask,
  input  logic [TAG_W-1:0]  wrBase,
  input  logic              wrValid,
  input  logic [EA_W-1:0]   lookAddr,
  output logic              hit,
  output logic [EA_W-1:0]   hitAddr
);

  logic [TAG_W-1:0]   entTag  [NUM_BAT];
  logic [MASK_W-1:0]  entMask [NUM_BAT];
  logic [TAG_W-1:0]   entBase [NUM_BAT];
  logic [NUM_BAT-1:0] entValid;
  logic [NUM_BAT-1:0] entHit;
  logic [EA_W-1:0]    entAddr [NUM_BAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < NUM_BAT; i++) begin
        entTag[i]  <= '0;
        entMask[i] <= '0;
        entBase[i] <= '0;
      end
    end else if (wrEn) begin
      entTag[wrIdx]   <= wrTag;
      entMask[wrIdx]  <= wrMask;
      entBase[wrIdx]  <= wrBase;
      entValid[wrIdx] <= wrValid;
    end
  end

  for (genvar i = 0; i < NUM_BAT; i++) begin : g_ent
    logic [MASK_W-1:0] diffBits;
    assign diffBits = (entTag[i][MASK_W-1:0] ^ lookAddr[EA_W-SEG_BITS-1:BLK_OFF]) & ~entMask[i];
    assign entHit[i] = entValid[i]
                    && (entTag[i][TAG_W-1:MASK_W] == lookAddr[EA_W-1:EA_W-SEG_BITS])
                    && (diffBits == '0);
    assign entAddr[i] = {entBase[i][TAG_W-1:MASK_W],
                         (entBase[i][MASK_W-1:0] & ~entMask[i])
                           | (lookAddr[EA_W-SEG_BITS-1:BLK_OFF] & entMask[i]),
                         lookAddr[BLK_OFF-1:0]};
  end

  // lowest-numbered matching entry wins
  always_comb begin
    hit     = 1'b0;
    hitAddr = '0;
    for (int i = NUM_BAT - 1; i >= 0; i--) begin
      if (entHit[i]) begin
        hit     = 1'b1;
        hitAddr = entAddr[i];
      end
    end
  end

endmodule

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int NUM_BAT  = 4,
  parameter int VSID_W   = 24,
  parameter int EA_W     = 32,
  parameter int SEG_BITS = 4,
  parameter int OFF_W    = 12,
  parameter int BLK_OFF  = 17,
  localparam int TAG_W   = EA_W - BLK_OFF,
  localparam int MASK_W  = EA_W - SEG_BITS - BLK_OFF,
  localparam int PFN_W   = EA_W - OFF_W,
  localparam int VA_W    = VSID_W + EA_W - SEG_BITS,
  localparam int SEG_CNT = 1 << SEG_BITS,
  localparam int BIDX_W  = (NUM_BAT > 1) ? $clog2(NUM_BAT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  input  logic [EA_W-1:0]     reqAddr,
  input  logic                reqIsInstr,
  input  logic                reqXlateOn,
  output logic                needWalk,
  input  logic [PFN_W-1:0]    pgRspPfn,
  output logic [VA_W-1:0]     pgReqVaddr,
  output logic [EA_W-1:0]     outAddr,
  output logic [1:0]          outSrc,
  output logic [1:0]          outFault,
  input  logic                cfgSegWe,
  input  logic [SEG_BITS-1:0] cfgSegIdx,
  input  logic [VSID_W-1:0]   cfgSegVsid,
  input  logic                cfgSegDirect,
  input  logic                cfgBatWe,
  input  logic                cfgBatInstr,
  input  logic [BIDX_W-1:0]   cfgBatIdx,
  input  logic [TAG_W-1:0]    cfgBatTag,
  input  logic [MASK_W-1:0]   cfgBatMask,
  input  logic [TAG_W-1:0]    cfgBatBase,
  input  logic                cfgBatValid
);

  logic [VSID_W-1:0]   segVsid [SEG_CNT];
  logic [SEG_CNT-1:0]  segDir;
  logic [SEG_BITS-1:0] segIdx;
  logic [1:0]          sideHit;
  logic [EA_W-1:0]     sideAddr [2];
  logic                batHit;
  logic [EA_W-1:0]     batAddr;
  logic [VA_W-1:0]     heldVaddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segDir <= '0;
      for (int i = 0; i < SEG_CNT; i++) segVsid[i] <= '0;
    end else if (cfgSegWe) begin
      segVsid[cfgSegIdx] <= cfgSegVsid;
      segDir[cfgSegIdx]  <= cfgSegDirect;
    end
  end

  // side 0 holds data entries, side 1 instruction entries
  for (genvar s = 0; s < 2; s++) begin : g_side
    xlate_bat_array #(
      .NUM_BAT (NUM_BAT),
      .EA_W    (EA_W),
      .SEG_BITS(SEG_BITS),
      .BLK_OFF (BLK_OFF)
    ) u_bat (
      .clk     (clk),
      .rstN    (rstN),
      .wrEn    (cfgBatWe && (cfgBatInstr == s[0])),
      .wrIdx   (cfgBatIdx),
      .wrTag   (cfgBatTag),
      .wrMask  (cfgBatMask),
      .wrBase  (cfgBatBase),
      .wrValid (cfgBatValid),
      .lookAddr(reqAddr),
      .hit     (sideHit[s]),
      .hitAddr (sideAddr[s])
    );
  end

  assign segIdx   = reqAddr[EA_W-1:EA_W-SEG_BITS];
  assign batHit   = sideHit[reqIsInstr];
  assign batAddr  = sideAddr[reqIsInstr];
  assign needWalk = reqXlateOn && !batHit && !segDir[segIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldVaddr <= '0;
      outAddr   <= '0;
      outSrc    <= SRC_REAL;
      outFault  <= FLT_NONE;
    end else if (strobe.capture) begin
      heldVaddr <= {segVsid[segIdx], reqAddr[EA_W-SEG_BITS-1:0]};
      outFault  <= FLT_NONE;
      if (!reqXlateOn) begin
        outAddr <= reqAddr;
        outSrc  <= SRC_REAL;
      end else if (batHit) begin
        outAddr <= batAddr;
        outSrc  <= SRC_BLOCK;
      end else begin
        outAddr <= '0;
        outSrc  <= SRC_PAGE;
        if (segDir[segIdx]) outFault <= reqIsInstr ? FLT_INSTR : FLT_DATA;
      end
    end else if (strobe.loadPage) begin
      outAddr <= {pgRspPfn, heldVaddr[OFF_W-1:0]};
    end
  end

  assign pgReqVaddr = heldVaddr;

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   needWalk,
  input  logic   pgRspValid,
  input  logic   outReady,
  output logic   reqReady,
  output logic   pgReqValid,
  output logic   outValid,
  output strobeT strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DONE} stateE;
  stateE state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        nextState      = needWalk ? ST_WALK : ST_DONE;
      end
      ST_WALK: if (pgRspValid) begin
        strobe.loadPage = 1'b1;
        nextState       = ST_DONE;
      end
      ST_DONE: if (outReady) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady   = (state == ST_IDLE);
  assign pgReqValid = (state == ST_WALK);
  assign outValid   = (state == ST_DONE);

endmodule

// File: rtl/ea_xlate_select.sv
module ea_xlate_select
  import xlate_pkg::*;
#(
  parameter int NUM_BAT  = 4,
  parameter int VSID_W   = 24,
  parameter int EA_W     = 32,
  parameter int SEG_BITS = 4,
  parameter int OFF_W    = 12,
  parameter int BLK_OFF  = 17,
  localparam int TAG_W   = EA_W - BLK_OFF,
  localparam int MASK_W  = EA_W - SEG_BITS - BLK_OFF,
  localparam int PFN_W   = EA_W - OFF_W,
  localparam int VA_W    = VSID_W + EA_W - SEG_BITS,
  localparam int BIDX_W  = (NUM_BAT > 1) ? $clog2(NUM_BAT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [EA_W-1:0]     reqAddr,
  input  logic                reqIsInstr,
  input  logic                reqXlateOn,
  output logic                outValid,
  input  logic                outReady,
  output logic [EA_W-1:0]     outAddr,
  output logic [1:0]          outSrc,
  output logic [1:0]          outFault,
  output logic                pgReqValid,
  output logic [VA_W-1:0]     pgReqVaddr,
  input  logic                pgRspValid,
  input  logic [PFN_W-1:0]    pgRspPfn,
  input  logic                cfgSegWe,
  input  logic [SEG_BITS-1:0] cfgSegIdx,
  input  logic [VSID_W-1:0]   cfgSegVsid,
  input  logic                cfgSegDirect,
  input  logic                cfgBatWe,
  input  logic                cfgBatInstr,
  input  logic [BIDX_W-1:0]   cfgBatIdx,
  input  logic [TAG_W-1:0]    cfgBatTag,
  input  logic [MASK_W-1:0]   cfgBatMask,
  input  logic [TAG_W-1:0]    cfgBatBase,
  input  logic                cfgBatValid
);

  strobeT strobe;
  logic   needWalk;

  xlate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .needWalk  (needWalk),
    .pgRspValid(pgRspValid),
    .outReady  (outReady),
    .reqReady  (reqReady),
    .pgReqValid(pgReqValid),
    .outValid  (outValid),
    .strobe    (strobe)
  );

  xlate_datapath #(
    .NUM_BAT (NUM_BAT),
    .VSID_W  (VSID_W),
    .EA_W    (EA_W),
    .SEG_BITS(SEG_BITS),
    .OFF_W   (OFF_W),
    .BLK_OFF (BLK_OFF)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqIsInstr  (reqIsInstr),
    .reqXlateOn  (reqXlateOn),
    .needWalk    (needWalk),
    .pgRspPfn    (pgRspPfn),
    .pgReqVaddr  (pgReqVaddr),
    .outAddr     (outAddr),
    .outSrc      (outSrc),
    .outFault    (outFault),
    .cfgSegWe    (cfgSegWe),
    .cfgSegIdx   (cfgSegIdx),
    .cfgSegVsid  (cfgSegVsid),
    .cfgSegDirect(cfgSegDirect),
    .cfgBatWe    (cfgBatWe),
    .cfgBatInstr (cfgBatInstr),
    .cfgBatIdx   (cfgBatIdx),
    .cfgBatTag   (cfgBatTag),
    .cfgBatMask  (cfgBatMask),
    .cfgBatBase  (cfgBatBase),
    .cfgBatValid (cfgBatValid)
  );

endmodule

// File: rtl/ea_xlate_select_chk.sv
module ea_xlate_select_chk #(
  parameter int EA_W  = 32,
  parameter int VA_W  = 52,
  parameter int PFN_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [EA_W-1:0]  reqAddr,
  input logic             reqIsInstr,
  input logic             reqXlateOn,
  input logic             outValid,
  input logic             outReady,
  input logic [EA_W-1:0]  outAddr,
  input logic [1:0]       outSrc,
  input logic [1:0]       outFault,
  input logic             pgReqValid,
  input logic [VA_W-1:0]  pgReqVaddr,
  input logic             pgRspValid,
  input logic [PFN_W-1:0] pgRspPfn
);

  logic accept;
  assign accept = reqValid && reqReady;

  assert_real_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !reqXlateOn) |=> (outValid && outSrc == 2'd0 && outFault == 2'd0
                                 && outAddr == $past(reqAddr) && !pgReqValid));

  assert_vaddr_index_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqXlateOn) |=> (!pgReqValid || pgReqVaddr[EA_W-5:0] == $past(reqAddr[EA_W-5:0])));

  assert_fetch_fault_kind_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqIsInstr) |=> (outFault != 2'd1));

  assert_data_fault_kind_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !reqIsInstr) |=> (outFault != 2'd2));

  assert_page_merge_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pgReqValid && pgRspValid) |=> (outValid && outSrc == 2'd2 && outFault == 2'd0
      && outAddr == {$past(pgRspPfn), $past(pgReqVaddr[EA_W-PFN_W-1:0])}));

  assert_block_low_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (outSrc != 2'd1 || outAddr[16:0] == $past(reqAddr[16:0])));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAddr) && $stable(outSrc) && $stable(outFault)));

  assert_one_phase_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({reqReady, pgReqValid, outValid}));

  assert_walk_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pgReqValid && !pgRspValid) |=> (pgReqValid && $stable(pgReqVaddr)));

endmodule

bind ea_xlate_select ea_xlate_select_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqAddr   (reqAddr),
  .reqIsInstr(reqIsInstr),
  .reqXlateOn(reqXlateOn),
  .outValid  (outValid),
  .outReady  (outReady),
  .outAddr   (outAddr),
  .outSrc    (outSrc),
  .outFault  (outFault),
  .pgReqValid(pgReqValid),
  .pgReqVaddr(pgReqVaddr),
  .pgRspValid(pgRspValid),
  .pgRspPfn  (pgRspPfn)
);

// File: tb/test_ea_xlate_select.sv
module test_ea_xlate_select;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady, reqIsInstr, reqXlateOn;
  logic [31:0] reqAddr;
  logic        outValid, outReady;
  logic [31:0] outAddr;
  logic [1:0]  outSrc, outFault;
  logic        pgReqValid, pgRspValid;
  logic [51:0] pgReqVaddr;
  logic [19:0] pgRspPfn;
  logic        cfgSegWe, cfgSegDirect;
  logic [3:0]  cfgSegIdx;
  logic [23:0] cfgSegVsid;
  logic        cfgBatWe, cfgBatInstr, cfgBatValid;
  logic [1:0]  cfgBatIdx;
  logic [14:0] cfgBatTag, cfgBatBase;
  logic [10:0] cfgBatMask;

  always #5 clk = ~clk;

  ea_xlate_select i_ea_xlate_select (.*);

  int nCmp = 0;
  int nBad = 0;

  // bench-side record of what was configured
  logic [23:0] mVsid [16];
  logic        mDir  [16];
  logic [14:0] mTag  [2][4];
  logic [10:0] mMask [2][4];
  logic [14:0] mBase [2][4];
  logic        mVal  [2][4];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  task automatic writeSeg(input int idx, input logic [23:0] vsid, input logic dir);
    @(negedge clk);
    cfgSegWe = 1'b1; cfgSegIdx = idx[3:0]; cfgSegVsid = vsid; cfgSegDirect = dir;
    @(negedge clk);
    cfgSegWe = 1'b0;
    mVsid[idx] = vsid; mDir[idx] = dir;
  endtask

  task automatic writeBat(input int side, input int idx, input logic [14:0] tag,
                          input logic [10:0] mask, input logic [14:0] base, input logic val);
    @(negedge clk);
    cfgBatWe = 1'b1; cfgBatInstr = side[0]; cfgBatIdx = idx[1:0];
    cfgBatTag = tag; cfgBatMask = mask; cfgBatBase = base; cfgBatValid = val;
    @(negedge clk);
    cfgBatWe = 1'b0;
    mTag[side][idx] = tag; mMask[side][idx] = mask; mBase[side][idx] = base; mVal[side][idx] = val;
  endtask

  // expected result from the requirements: kind 0 real, 1 block, 2 fault, 3 page walk
  function automatic int predict(input logic [31:0] ea, input bit instr, input bit xon,
                                 output logic [31:0] addr, output logic [1:0] src, output logic [1:0] flt);
    int side;
    side = instr ? 1 : 0;
    flt = 2'd0;
    if (!xon) begin
      addr = ea; src = 2'd0; return 0;
    end
    for (int i = 0; i < 4; i++) begin
      if (mVal[side][i] && mTag[side][i][14:11] == ea[31:28]
          && (((mTag[side][i][10:0] ^ ea[27:17]) & ~mMask[side][i]) == 11'd0)) begin
        addr = {mBase[side][i][14:11],
                (mBase[side][i][10:0] & ~mMask[side][i]) | (ea[27:17] & mMask[side][i]), ea[16:0]};
        src = 2'd1;
        return 1;
      end
    end
    src = 2'd2;
    addr = 32'd0;
    if (mDir[ea[31:28]]) begin
      flt = instr ? 2'd2 : 2'd1;
      return 2;
    end
    return 3;
  endfunction

  task automatic runReq(input string tag, input logic [31:0] ea, input bit instr, input bit xon,
                        input int holdCycles, input bit midWrite);
    logic [31:0] eAddr;
    logic [1:0]  eSrc, eFlt;
    logic [51:0] eVa;
    logic [19:0] pfn;
    int kind;
    string lbl;
    kind = predict(ea, instr, xon, eAddr, eSrc, eFlt);
    eVa = {mVsid[ea[31:28]], ea[27:0]};
    lbl = (kind == 0) ? "R1" : (kind == 1) ? "R5" : (kind == 2) ? "R3" : "R4";
    @(negedge clk);
    chk({tag, " R9"}, "reqReady idle", reqReady, 1);
    reqValid = 1'b1; reqAddr = ea; reqIsInstr = instr; reqXlateOn = xon;
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " R9"}, "reqReady busy", reqReady, 0);
    if (kind == 3) begin
      chk({tag, " R2"}, "pgReqValid", pgReqValid, 1);
      chk({tag, " R2"}, "pgReqVaddr", pgReqVaddr, eVa);
      chk({tag, " R2"}, "outValid during walk", outValid, 0);
      if (midWrite) begin
        cfgSegWe = 1'b1; cfgSegIdx = ea[31:28]; cfgSegVsid = ~mVsid[ea[31:28]]; cfgSegDirect = 1'b0;
        @(negedge clk);
        cfgSegWe = 1'b0;
        mVsid[ea[31:28]] = ~mVsid[ea[31:28]]; mDir[ea[31:28]] = 1'b0;
        chk("R10", "pgReqValid after write", pgReqValid, 1);
        chk("R10", "pgReqVaddr after write", pgReqVaddr, eVa);
      end
      pfn = ea[31:12] ^ 20'hA5A5A;
      pgRspValid = 1'b1; pgRspPfn = pfn;
      @(negedge clk);
      pgRspValid = 1'b0;
      eAddr = {pfn, ea[11:0]};
    end else begin
      chk({tag, " R6"}, "no page request", pgReqValid, 0);
    end
    chk({tag, " ", lbl}, "outValid", outValid, 1);
    chk({tag, " ", lbl}, "outAddr", outAddr, eAddr);
    chk({tag, " ", lbl}, "outSrc", outSrc, eSrc);
    chk({tag, " ", lbl}, "outFault", outFault, eFlt);
    for (int h = 0; h < holdCycles; h++) begin
      @(negedge clk);
      chk("R9", "held outValid", outValid, 1);
      chk("R9", "held outAddr", outAddr, eAddr);
      chk("R9", "held outSrc", outSrc, eSrc);
    end
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chk("R9", "outValid after take", outValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] ea;
    logic [10:0] mk;
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqIsInstr = 1'b0; reqXlateOn = 1'b0;
    outReady = 1'b0; pgRspValid = 1'b0; pgRspPfn = '0;
    cfgSegWe = 1'b0; cfgSegIdx = '0; cfgSegVsid = '0; cfgSegDirect = 1'b0;
    cfgBatWe = 1'b0; cfgBatInstr = 1'b0; cfgBatIdx = '0; cfgBatTag = '0; cfgBatMask = '0;
    cfgBatBase = '0; cfgBatValid = 1'b0;
    for (int i = 0; i < 16; i++) begin mVsid[i] = '0; mDir[i] = 1'b0; end
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 4; i++) begin
        mTag[s][i] = '0; mMask[s][i] = '0; mBase[s][i] = '0; mVal[s][i] = 1'b0;
      end
    repeat (3) @(negedge clk);
    chk("R11", "reqReady in reset", reqReady, 1);
    chk("R11", "outValid in reset", outValid, 0);
    chk("R11", "pgReqValid in reset", pgReqValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11", "reqReady after reset", reqReady, 1);
    // fresh registers: page walk with VSID 0, no block hit
    runReq("R11", 32'h7123_4567, 1'b0, 1'b1, 0, 1'b0);
    runReq("R11", 32'hF00D_1234, 1'b1, 1'b1, 0, 1'b0);

    // real mode, including segments later marked direct-store
    for (int i = 0; i < 4; i++) begin
      runReq("R1", 32'h3000_0001 + i * 32'h4321_0FED, i[0], 1'b0, 0, 1'b0);
    end

    // program segments: VSID pattern, every segment with index mod 5 == 3 direct-store
    for (int i = 0; i < 16; i++) writeSeg(i, 24'h010101 * i ^ 24'h00005A, (i % 5) == 3);
    runReq("R1", 32'h3ABC_DEF0, 1'b0, 1'b0, 0, 1'b0);

    // sweep all segments for fetch and data
    for (int sg = 0; sg < 16; sg++)
      for (int ins = 0; ins < 2; ins++) begin
        ea = {sg[3:0], 28'h0ABC123 + sg * 28'h0011111 + ins * 28'h0000777};
        runReq(mDir[sg] ? "R3" : "R2", ea, ins[0], 1'b1, 0, 1'b0);
      end

    // block sizes 128 KB .. 256 MB on data entry 0, on direct-store segment 3
    for (int k = 0; k < 12; k++) begin
      mk = 11'((32'd1 << k) - 1);
      writeBat(0, 0, {4'h3, 11'h5A3}, mk, {4'hC, 11'h2D6}, 1'b1);
      ea = {4'h3, 11'h5A3, 17'h1F0F3};
      runReq("R5 R6", ea, 1'b0, 1'b1, 0, 1'b0);
      runReq("R5", ea ^ {4'h0, mk, 17'h0}, 1'b0, 1'b1, 0, 1'b0);
      if (k < 11) runReq("R5 R6", ea ^ (32'd1 << (17 + k)), 1'b0, 1'b1, 0, 1'b0);
      runReq("R7", ea, 1'b1, 1'b1, 0, 1'b0);
    end
    writeBat(0, 0, '0, '0, '0, 1'b0);

    // priority among matching entries on non-direct segment 4
    writeBat(0, 1, {4'h4, 11'h011}, 11'h000, {4'h1, 11'h111}, 1'b1);
    writeBat(0, 2, {4'h4, 11'h000}, 11'h7FF, {4'h2, 11'h000}, 1'b1);
    writeBat(0, 3, {4'h4, 11'h010}, 11'h00F, {4'h3, 11'h333}, 1'b1);
    ea = {4'h4, 11'h011, 17'h0ABCD};
    runReq("R8 R6", ea, 1'b0, 1'b1, 0, 1'b0);
    writeBat(0, 1, {4'h4, 11'h011}, 11'h000, {4'h1, 11'h111}, 1'b0);
    runReq("R8", ea, 1'b0, 1'b1, 0, 1'b0);
    writeBat(1, 3, {4'h4, 11'h011}, 11'h000, {4'h7, 11'h777}, 1'b1);
    runReq("R7", ea, 1'b1, 1'b1, 0, 1'b0);
    runReq("R7", ea, 1'b0, 1'b1, 0, 1'b0);

    // configuration write during a walk, then next request sees it
    runReq("R10", 32'h0123_4ABC, 1'b0, 1'b1, 0, 1'b1);
    runReq("R10", 32'h0123_4ABC, 1'b0, 1'b1, 0, 1'b0);

    // holding results while the consumer stalls
    runReq("R9", 32'hDEAD_BEEF, 1'b0, 1'b0, 3, 1'b0);
    runReq("R9", 32'h1555_0123, 1'b1, 1'b1, 4, 1'b0);

    finishRun();
  end

endmodule